// File: doc/BRIEF.md
# Indirect Configuration Register Bank

This block is the host-side register file of a two-wire serial bus controller. The host sees only two locations: a pointer register and a data port. It writes the pointer to choose one of the internal configuration registers. It then reads or writes that register through the data port. The internal registers hold the controller's own bus address, a bus timeout value, an operating mode, and the clock low-phase and high-phase counts. Each of these values also drives a configuration output that goes to the bus engine.

One pointer value selects a reset slot instead of a register. When the host writes the two-byte unlock key to this slot in the correct order, the block does two things. It sends a one-clock soft-reset pulse to the rest of the controller. It also returns its own registers and its pointer to their defaults. A wrong byte clears the partial key, so a stray write cannot reset the controller.

Top module: `ireg_bank`

## Requirements
- R1: After the asynchronous reset (rst_n low), the outputs take these values: ownAddr 0x00, timeoutVal 0xFF, modeVal 0x00, sclLowCnt 0x9D, sclHighCnt 0x86. The pointer is 0, rdData is 0x00 and softRst is low.
- R2: A write with hostSel=0 loads the pointer from wrData[2:0]. A read with hostSel=0 returns the pointer zero-extended to 8 bits.
- R3: A write with hostSel=1 loads wrData into the register the pointer selects. The pointer encoding is 0 own address, 1 timeout, 2 mode, 3 low count, 4 high count. The matching output shows the new value from the clock edge of the write onward.
- R4: A read strobe captures the addressed value into rdData at the clock edge. rdData holds that value until the next read strobe.
- R5: A value written to the own-address register still reads back unchanged after other registers have been written.
- R6: Pointer value 5 is the reset slot. Writing 0xA5 and then 0x5A to it through the data port raises softRst for exactly one clock cycle. The pulse starts at the edge of the 0x5A write.
- R7: At that same edge, all five registers return to their R1 defaults and the pointer becomes 0.
- R8: Any other sequence of slot writes clears the key tracker and causes no reset. This covers 0x5A with no 0xA5 before it, and any byte other than 0x5A following 0xA5, including a second 0xA5.
- R9: Reading the reset slot returns 0x00.
- R10: Pointer values 6 and 7 read as 0x00, and data-port writes to them change no output.
- R11: The key tracker is affected only by data-port writes to the reset slot. Pointer writes and reads made between the two key bytes leave a started key intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | 0 selects the pointer, 1 selects the data port |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Captured read data |
| ownAddr | output | 8 | Own bus address |
| timeoutVal | output | 8 | Bus timeout setting |
| modeVal | output | 8 | Operating mode setting |
| sclLowCnt | output | 8 | Clock low-phase count |
| sclHighCnt | output | 8 | Clock high-phase count |
| softRst | output | 1 | One-cycle soft-reset pulse |

## Verification
The hardest state to reach is a key that has been started and then interrupted. The bench creates it in three ways: by writing 0xA5 twice, by writing a non-key byte between the two key bytes, and by moving the pointer away and back between them. It then checks whether the final 0x5A fires the pulse. Before each reset attempt, the registers are loaded with values that differ from their defaults. This makes both a missing restore and a false restore visible on the configuration outputs.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int NUM_REGS = 5;
  localparam int RST_SLOT = NUM_REGS;
  localparam int PTR_W = $clog2(NUM_REGS + 1);
  localparam logic [7:0] KEY_FIRST = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  typedef struct packed {
    logic ptrLoad;
    logic regLoad;
    logic readCap;
    logic bankClear;
  } bank_ctrl_t;
endpackage

// File: rtl/ireg_ctrl.sv
module ireg_ctrl
  import ireg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hostSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [PTR_W-1:0]    ptr,
  output bank_ctrl_t          ctrl,
  output logic                softRst
);
  logic keyArmed;
  logic slotWrite;
  logic keyDone;

  assign slotWrite = wrEn && hostSel && (ptr == PTR_W'(RST_SLOT));
  assign keyDone   = slotWrite && keyArmed && (wrData[7:0] == KEY_SECOND);

  always_comb begin
    ctrl.ptrLoad   = wrEn && !hostSel;
    ctrl.regLoad   = wrEn && hostSel && (ptr < PTR_W'(NUM_REGS));
    ctrl.readCap   = rdEn;
    ctrl.bankClear = keyDone;
  end

  // Tracker: armed only by KEY_FIRST from idle; any other slot write drops it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keyArmed <= 1'b0;
      softRst  <= 1'b0;
    end else begin
      softRst <= keyDone;
      if (slotWrite) keyArmed <= !keyArmed && (wrData[7:0] == KEY_FIRST);
    end
  end
endmodule

// File: rtl/ireg_dpath.sv
module ireg_dpath
  import ireg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hostSel,
  input  logic [DATA_W-1:0]                 wrData,
  input  bank_ctrl_t                        ctrl,
  output logic [PTR_W-1:0]                  ptr,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   cfgBus,
  output logic [DATA_W-1:0]                 rdData
);
  logic [DATA_W-1:0] readMux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr <= '0;
    else if (ctrl.bankClear) ptr <= '0;
    else if (ctrl.ptrLoad)   ptr <= wrData[PTR_W-1:0];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF = RESET_VALS[i*DATA_W +: DATA_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    cfgBus[i] <= DEF;
      else if (ctrl.bankClear)                       cfgBus[i] <= DEF;
      else if (ctrl.regLoad && ptr == PTR_W'(i))     cfgBus[i] <= wrData;
    end
  end

  always_comb begin
    readMux = '0;
    if (!hostSel) readMux = DATA_W'(ptr);
    else begin
      for (int k = 0; k < NUM_REGS; k++)
        if (ptr == PTR_W'(k)) readMux = cfgBus[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rdData <= '0;
    else if (ctrl.readCap) rdData <= readMux;
  end
endmodule

// File: rtl/ireg_bank.sv
module ireg_bank
  import ireg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OWN_DEF  = 8'h00,
  parameter logic [DATA_W-1:0] TOUT_DEF = 8'hFF,
  parameter logic [DATA_W-1:0] MODE_DEF = 8'h00,
  parameter logic [DATA_W-1:0] LOW_DEF  = 8'h9D,
  parameter logic [DATA_W-1:0] HIGH_DEF = 8'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ownAddr,
  output logic [DATA_W-1:0] timeoutVal,
  output logic [DATA_W-1:0] modeVal,
  output logic [DATA_W-1:0] sclLowCnt,
  output logic [DATA_W-1:0] sclHighCnt,
  output logic              softRst
);
  localparam logic [NUM_REGS*DATA_W-1:0] RESET_VALS =
    {HIGH_DEF, LOW_DEF, MODE_DEF, TOUT_DEF, OWN_DEF};

  bank_ctrl_t                            ctrl;
  logic [PTR_W-1:0]                      curPtr;
  logic [NUM_REGS-1:0][DATA_W-1:0]       cfgBus;

  ireg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostSel(hostSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .ptr(curPtr), .ctrl(ctrl), .softRst(softRst)
  );

  ireg_dpath #(.DATA_W(DATA_W), .RESET_VALS(RESET_VALS)) u_dpath (
    .clk(clk), .rst_n(rst_n), .hostSel(hostSel), .wrData(wrData),
    .ctrl(ctrl), .ptr(curPtr), .cfgBus(cfgBus), .rdData(rdData)
  );

  assign ownAddr    = cfgBus[0];
  assign timeoutVal = cfgBus[1];
  assign modeVal    = cfgBus[2];
  assign sclLowCnt  = cfgBus[3];
  assign sclHighCnt = cfgBus[4];
endmodule

// File: rtl/ireg_bank_chk.sv
module ireg_bank_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W = 3,
  parameter logic [DATA_W-1:0] OWN_DEF  = 8'h00,
  parameter logic [DATA_W-1:0] TOUT_DEF = 8'hFF,
  parameter logic [DATA_W-1:0] MODE_DEF = 8'h00,
  parameter logic [DATA_W-1:0] LOW_DEF  = 8'h9D,
  parameter logic [DATA_W-1:0] HIGH_DEF = 8'h86
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hostSel,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] ownAddr,
  input logic [DATA_W-1:0] timeoutVal,
  input logic [DATA_W-1:0] modeVal,
  input logic [DATA_W-1:0] sclLowCnt,
  input logic [DATA_W-1:0] sclHighCnt,
  input logic              softRst,
  input logic [PTR_W-1:0]  ptr
);
  // R6
  soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> !softRst);

  // R6
  key_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |-> $past(wrEn && hostSel && ptr == PTR_W'(5) && wrData[7:0] == 8'h5A));

  // R7
  clear_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |-> (ownAddr == OWN_DEF && timeoutVal == TOUT_DEF && modeVal == MODE_DEF
                 && sclLowCnt == LOW_DEF && sclHighCnt == HIGH_DEF && ptr == '0));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrEn && hostSel && ptr > PTR_W'(5)) |->
      ($stable(ownAddr) && $stable(timeoutVal) && $stable(modeVal)
       && $stable(sclLowCnt) && $stable(sclHighCnt)));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rdEn) |-> $stable(rdData));
endmodule

bind ireg_bank ireg_bank_chk #(
  .DATA_W(DATA_W), .PTR_W(ireg_pkg::PTR_W), .OWN_DEF(OWN_DEF), .TOUT_DEF(TOUT_DEF),
  .MODE_DEF(MODE_DEF), .LOW_DEF(LOW_DEF), .HIGH_DEF(HIGH_DEF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hostSel(hostSel), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .ownAddr(ownAddr), .timeoutVal(timeoutVal),
  .modeVal(modeVal), .sclLowCnt(sclLowCnt), .sclHighCnt(sclHighCnt),
  .softRst(softRst), .ptr(curPtr)
);

// File: tb/ireg_bank_tb.sv
module ireg_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, ownAddr, timeoutVal, modeVal, sclLowCnt, sclHighCnt;
  logic softRst;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ireg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .hostSel(hostSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .ownAddr(ownAddr), .timeoutVal(timeoutVal),
    .modeVal(modeVal), .sclLowCnt(sclLowCnt), .sclHighCnt(sclHighCnt), .softRst(softRst)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); hostSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic hostRead(input logic sel, output logic [7:0] d);
    @(negedge clk); hostSel = sel; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic checkDefaults(input string req);
    check(req, "ownAddr", ownAddr, 8'h00);
    check(req, "timeoutVal", timeoutVal, 8'hFF);
    check(req, "modeVal", modeVal, 8'h00);
    check(req, "sclLowCnt", sclLowCnt, 8'h9D);
    check(req, "sclHighCnt", sclHighCnt, 8'h86);
  endtask

  task automatic loadAll();
    for (int i = 0; i < 5; i++) begin
      hostWrite(1'b0, 8'(i));
      hostWrite(1'b1, 8'h10 + 8'(i));
    end
  endtask

  task automatic test_reset();
    logic [7:0] d;
    checkDefaults("R1");
    check("R1", "softRst", softRst, 0);
    check("R1", "rdData", rdData, 8'h00);
    hostRead(1'b0, d);
    check("R1", "pointer", d, 0);
  endtask

  task automatic test_pointer();
    logic [7:0] d;
    hostWrite(1'b0, 8'hF3);
    hostRead(1'b0, d);
    check("R2", "pointer low bits", d, 3);
  endtask

  task automatic test_write_read();
    logic [7:0] d;
    loadAll();
    check("R3", "ownAddr", ownAddr, 8'h10);
    check("R3", "timeoutVal", timeoutVal, 8'h11);
    check("R3", "modeVal", modeVal, 8'h12);
    check("R3", "sclLowCnt", sclLowCnt, 8'h13);
    check("R3", "sclHighCnt", sclHighCnt, 8'h14);
    hostWrite(1'b0, 8'd2);
    hostRead(1'b1, d);
    check("R4", "read mode", d, 8'h12);
    hostWrite(1'b0, 8'd4);
    repeat (3) @(negedge clk);
    check("R4", "rdData held", rdData, 8'h12);
  endtask

  task automatic test_own_persist();
    logic [7:0] d;
    hostWrite(1'b0, 8'd0); hostWrite(1'b1, 8'h5C);
    hostWrite(1'b0, 8'd1); hostWrite(1'b1, 8'h77);
    hostWrite(1'b0, 8'd3); hostWrite(1'b1, 8'h21);
    hostWrite(1'b0, 8'd0);
    hostRead(1'b1, d);
    check("R5", "own readback", d, 8'h5C);
  endtask

  task automatic test_key_ok();
    logic [7:0] d;
    loadAll();
    hostWrite(1'b0, 8'd5);
    hostWrite(1'b1, 8'hA5);
    check("R6", "no pulse after first byte", softRst, 0);
    hostWrite(1'b1, 8'h5A);
    check("R6", "pulse high", softRst, 1);
    checkDefaults("R7");
    @(negedge clk);
    check("R6", "pulse one cycle", softRst, 0);
    hostRead(1'b0, d);
    check("R7", "pointer cleared", d, 0);
  endtask

  task automatic badSeq(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input bit three);
    hostWrite(1'b0, 8'd1); hostWrite(1'b1, 8'h33);
    hostWrite(1'b0, 8'd5);
    hostWrite(1'b1, a); check("R8", "no pulse", softRst, 0);
    hostWrite(1'b1, b); check("R8", "no pulse", softRst, 0);
    if (three) begin hostWrite(1'b1, c); check("R8", "no pulse", softRst, 0); end
    check("R8", "timeout kept", timeoutVal, 8'h33);
  endtask

  task automatic test_key_bad();
    badSeq(8'h5A, 8'h5A, 8'h00, 1'b0);
    badSeq(8'hA5, 8'h00, 8'h5A, 1'b1);
    badSeq(8'hA5, 8'hA5, 8'h5A, 1'b1);
  endtask

  task automatic test_key_interleave();
    logic [7:0] d;
    hostWrite(1'b0, 8'd2); hostWrite(1'b1, 8'h44);
    hostWrite(1'b0, 8'd5);
    hostWrite(1'b1, 8'hA5);
    hostWrite(1'b0, 8'd2);
    hostRead(1'b1, d);
    hostWrite(1'b0, 8'd5);
    hostWrite(1'b1, 8'h5A);
    check("R11", "pulse after interleave", softRst, 1);
    check("R11", "mode restored", modeVal, 8'h00);
  endtask

  task automatic test_slot_read();
    logic [7:0] d;
    hostWrite(1'b0, 8'd0); hostWrite(1'b1, 8'hEE);
    hostRead(1'b1, d);
    hostWrite(1'b0, 8'd5);
    hostRead(1'b1, d);
    check("R9", "reset slot read", d, 8'h00);
  endtask

  task automatic test_unmapped();
    logic [7:0] d;
    loadAll();
    for (int p = 6; p < 8; p++) begin
      hostWrite(1'b0, 8'(p));
      hostWrite(1'b1, 8'hC9);
      hostRead(1'b1, d);
      check("R10", "unmapped read", d, 8'h00);
    end
    check("R10", "ownAddr", ownAddr, 8'h10);
    check("R10", "timeoutVal", timeoutVal, 8'h11);
    check("R10", "modeVal", modeVal, 8'h12);
    check("R10", "sclLowCnt", sclLowCnt, 8'h13);
    check("R10", "sclHighCnt", sclHighCnt, 8'h14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_pointer();
    test_write_read();
    test_own_persist();
    test_key_ok();
    test_key_bad();
    test_key_interleave();
    test_slot_read();
    test_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule